// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One 16-bit timer channel that counts ticks of a timer clock enable and drives a single output level. A load strobe delivers an initial value and a 3-bit mode code in one cycle. The channel then runs one of six behaviours: a terminal-count flag, a gate-triggered one-shot, a periodic rate pulse, a square wave, a software-started strobe or a gate-triggered strobe. The current count is readable at all times. The gate input either holds counting or restarts it, depending on the mode.

The channel does not decode a bus, sequence bytes or count in BCD. Its output is a plain level that a neighbour samples. The state is held as an elapsed-tick position measured against the loaded value, so every mode's output and count come from the same few registers.

Top module: `ivt_channel`

## Requirements
- R1: A load value of 0 stands for 65536 ticks. The count reads 0x0000 right after such a load. In mode 0 the output rises after exactly 65536 counted ticks.
- R2: After reset the channel is in mode 3 with a load value of 65536. The count reads 0x0000 and the output is high. Ticks with the gate high then step the count down by two (0xFFFE, 0xFFFC, ...).
- R3: Mode 0 (code 0): after a load the output is low until N counted ticks have passed. It then goes high and stays high until the next load.
- R4: Mode 1 (code 1): after a load the output is high. A gate rising edge drives it low, and it returns high after N ticks. Ticks count in this mode whatever the gate level.
- R5: Mode 2 (code 2): the period is N ticks. The output is low for exactly one tick each time the position wraps to the start of a period. It is never low straight after a load or a restart. The count reads N minus the position.
- R6: Mode 3 (code 3): the output is high for the first ceil(N/2) ticks of each period and low for the rest. The count reads N minus twice the position, folded modulo N, so it falls by two per tick and reloads to N each period.
- R7: Modes 4 and 5 (codes 4, 5): the output is low for exactly one tick when the elapsed ticks equal N, and high otherwise. Mode 4 starts counting at the load. Mode 5 stays high after a load until a gate rising edge starts it.
- R8: In modes 1, 2, 3 and 5, a gate rising edge (gate high now, low in the previous cycle) restarts counting from the loaded value, also in the middle of a count. The count then reads N.
- R9: In modes 0, 2, 3 and 4, ticks are ignored while the gate is low. In modes 2 and 3 the output is high from the cycle after the gate is sampled low.
- R10: In modes 0, 1, 4 and 5 the count falls by one per counted tick and wraps from 0x0000 to 0xFFFF.
- R11: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R12: A load has priority over a gate edge, and a gate edge has priority over a tick arriving in the same cycle. The displaced tick is lost. The count reads the loaded value the cycle after a load. Counting starts with the next tick. Without a tick, load or restart the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer clock enable, one pulse per timer period |
| gate | input | 1 | Gate level, sampled each clock |
| load | input | 1 | Load strobe for value and mode |
| load_value | input | 16 | Initial value, 0 meaning 65536 |
| load_mode | input | 3 | Mode code 0..7 |
| count | output | 16 | Current readable count |
| out | output | 1 | Channel output level |

## Verification
Three events can fall in the same clock: a tick, a load and a gate rising edge. The bench drives a tick in the same cycle as a load, and a tick in the same cycle as a gate rising edge in a restartable mode. It also drives a load together with a gate edge. A reference model built from the priority rule predicts the count and output. The count must show the freshly loaded value in the next cycle, with no tick consumed, and counting must resume only on the tick after.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   typedef enum logic [2:0] {
      MODE_TERM    = 3'd0,
      MODE_ONESHOT = 3'd1,
      MODE_RATE    = 3'd2,
      MODE_SQUARE  = 3'd3,
      MODE_SWSTB   = 3'd4,
      MODE_HWSTB   = 3'd5
   } ivt_mode_e;

   // codes 6 and 7 alias the periodic modes
   function automatic ivt_mode_e fold_mode(input logic [2:0] raw);
      case (raw)
         3'd6:    fold_mode = MODE_RATE;
         3'd7:    fold_mode = MODE_SQUARE;
         default: fold_mode = ivt_mode_e'(raw);
      endcase
   endfunction

   // single-shot modes: readable count is a free wrapping down-counter
   function automatic logic is_single(input ivt_mode_e m);
      is_single = (m == MODE_TERM) || (m == MODE_ONESHOT) ||
                  (m == MODE_SWSTB) || (m == MODE_HWSTB);
   endfunction

   // gate rising edge restarts the count
   function automatic logic gate_restarts(input ivt_mode_e m);
      gate_restarts = (m == MODE_ONESHOT) || (m == MODE_RATE) ||
                      (m == MODE_SQUARE) || (m == MODE_HWSTB);
   endfunction

   // gate-started modes: count regardless of gate level, idle after a load
   function automatic logic gate_started(input ivt_mode_e m);
      gate_started = (m == MODE_ONESHOT) || (m == MODE_HWSTB);
   endfunction

endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
   import ivt_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter bit GATE_IDLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             gate,
   input  logic             load,
   input  logic [WIDTH-1:0] load_value,
   input  logic [2:0]       load_mode,
   output ivt_mode_e        mode_q,
   output logic [WIDTH:0]   reload_q,
   output logic             gate_q,
   output logic             restart,
   output logic             arm,
   output logic [WIDTH:0]   start_value,
   output logic             advance
);

   localparam logic [WIDTH:0] FULL_RANGE = {1'b1, {WIDTH{1'b0}}};

   ivt_mode_e        new_mode;
   logic [WIDTH:0]   new_reload;
   logic             gate_rise;

   always_comb begin
      new_mode    = fold_mode(load_mode);
      new_reload  = (load_value == '0) ? FULL_RANGE : {1'b0, load_value};
      gate_rise   = gate & ~gate_q;
      // priority: load, then gate restart, then tick
      restart     = load | (gate_rise & gate_restarts(mode_q));
      arm         = load & gate_started(new_mode);
      start_value = load ? new_reload : reload_q;
      advance     = tick & ~restart & (gate | gate_started(mode_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_SQUARE;
         reload_q <= FULL_RANGE;
         gate_q   <= GATE_IDLE;
      end else begin
         gate_q <= gate;
         if (load) begin
            mode_q   <= new_mode;
            reload_q <= new_reload;
         end
      end
   end

   // R12: a load is never accompanied by a counted tick
   a_r12_load_blocks_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (load && tick) |-> !advance);

endmodule

// File: rtl/ivt_elapsed.sv
module ivt_elapsed
   import ivt_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ivt_mode_e        mode,
   input  logic [WIDTH:0]   reload,
   input  logic             restart,
   input  logic             arm,
   input  logic [WIDTH:0]   start_value,
   input  logic             advance,
   output logic [WIDTH:0]   elapsed_q,
   output logic [WIDTH-1:0] down_q,
   output logic             wrapped_q
);

   logic [WIDTH:0] past_end;
   logic [WIDTH:0] last_pos;

   always_comb begin
      past_end = reload + 1'b1;   // parking position of a finished single shot
      last_pos = reload - 1'b1;   // final position of a periodic cycle
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_q <= '0;
         down_q    <= '0;
         wrapped_q <= 1'b0;
      end else if (restart) begin
         elapsed_q <= arm ? (start_value + 1'b1) : '0;
         down_q    <= start_value[WIDTH-1:0];
         wrapped_q <= 1'b0;
      end else if (advance) begin
         if (is_single(mode)) begin
            down_q <= down_q - 1'b1;
            if (elapsed_q != past_end)
               elapsed_q <= elapsed_q + 1'b1;
         end else begin
            wrapped_q <= 1'b1;
            elapsed_q <= (elapsed_q == last_pos) ? '0 : (elapsed_q + 1'b1);
         end
      end
   end

   // R10: single-shot count steps down by one per counted tick, modulo 2^WIDTH
   a_r10_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !restart && is_single(mode)) |=> (down_q == WIDTH'($past(down_q) - 1'b1)));

endmodule

// File: rtl/ivt_outdec.sv
module ivt_outdec
   import ivt_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  ivt_mode_e        mode,
   input  logic [WIDTH:0]   reload,
   input  logic [WIDTH:0]   elapsed,
   input  logic [WIDTH-1:0] down,
   input  logic             wrapped,
   input  logic             gate_q,
   output logic [WIDTH-1:0] count,
   output logic             level
);

   logic [WIDTH+1:0] twice;
   logic [WIDTH+1:0] reload_ext;
   logic [WIDTH-1:0] folded;
   logic [WIDTH:0]   half_high;

   always_comb begin
      twice      = {elapsed, 1'b0};
      reload_ext = {1'b0, reload};
      folded     = (twice >= reload_ext) ? WIDTH'(twice - reload_ext) : WIDTH'(twice);
      half_high  = (reload >> 1) + {{WIDTH{1'b0}}, reload[0]};

      case (mode)
         MODE_TERM, MODE_ONESHOT: begin
            level = (elapsed >= reload);
            count = down;
         end
         MODE_RATE: begin
            level = gate_q ? ~(wrapped & (elapsed == '0)) : 1'b1;
            count = reload[WIDTH-1:0] - elapsed[WIDTH-1:0];
         end
         MODE_SWSTB, MODE_HWSTB: begin
            level = (elapsed != reload);
            count = down;
         end
         default: begin
            level = gate_q ? (elapsed < half_high) : 1'b1;
            count = reload[WIDTH-1:0] - folded;
         end
      endcase
   end

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
   import ivt_pkg::*;
#(
   parameter int WIDTH   = 16,
   parameter int CHANNEL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             gate,
   input  logic             load,
   input  logic [WIDTH-1:0] load_value,
   input  logic [2:0]       load_mode,
   output logic [WIDTH-1:0] count,
   output logic             out
);

   localparam bit GATE_IDLE = (CHANNEL != 2);

   generate
      if (WIDTH < 2 || WIDTH > 30) begin : g_bad_width
         $error("ivt_channel: WIDTH out of supported range");
      end
      if (CHANNEL < 0 || CHANNEL > 2) begin : g_bad_channel
         $error("ivt_channel: CHANNEL must be 0, 1 or 2");
      end
   endgenerate

   ivt_mode_e        mode_q;
   logic [WIDTH:0]   reload_q;
   logic             gate_q;
   logic             restart;
   logic             arm;
   logic [WIDTH:0]   start_value;
   logic             advance;
   logic [WIDTH:0]   elapsed_q;
   logic [WIDTH-1:0] down_q;
   logic             wrapped_q;

   ivt_ctrl #(.WIDTH(WIDTH), .GATE_IDLE(GATE_IDLE)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .gate        (gate),
      .load        (load),
      .load_value  (load_value),
      .load_mode   (load_mode),
      .mode_q      (mode_q),
      .reload_q    (reload_q),
      .gate_q      (gate_q),
      .restart     (restart),
      .arm         (arm),
      .start_value (start_value),
      .advance     (advance)
   );

   ivt_elapsed #(.WIDTH(WIDTH)) u_elapsed (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode_q),
      .reload      (reload_q),
      .restart     (restart),
      .arm         (arm),
      .start_value (start_value),
      .advance     (advance),
      .elapsed_q   (elapsed_q),
      .down_q      (down_q),
      .wrapped_q   (wrapped_q)
   );

   ivt_outdec #(.WIDTH(WIDTH)) u_outdec (
      .mode    (mode_q),
      .reload  (reload_q),
      .elapsed (elapsed_q),
      .down    (down_q),
      .wrapped (wrapped_q),
      .gate_q  (gate_q),
      .count   (count),
      .level   (out)
   );

   // R12: the cycle after a load the count shows the loaded value
   a_r12_load_shows_value: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_value)));

   // R12: with nothing to do the count holds
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !advance) |=> $stable(count));

   // R3: terminal-count output stays high until the next load
   a_r3_sticky_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_TERM && out && !load) |=> out);

   // R5: the rate pulse lasts one counted tick
   a_r5_single_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RATE && !out && advance && reload_q > 1) |=> out);

   // R7: the strobe lasts one counted tick
   a_r7_single_tick_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MODE_SWSTB || mode_q == MODE_HWSTB) && !out && advance) |=> out);

   // R9: a low gate forces the periodic output high
   a_r9_gate_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == MODE_RATE || mode_q == MODE_SQUARE) && !gate && !load) |=> out);

endmodule

// File: tb/ivt_channel_bench.sv
module ivt_channel_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        gate = 1'b1;
   logic        load = 1'b0;
   logic [15:0] load_value = '0;
   logic [2:0]  load_mode = '0;
   logic [15:0] count;
   logic        out;

   always #(CLK_PERIOD/2) clk = ~clk;

   ivt_channel u_ivt_channel (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .gate       (gate),
      .load       (load),
      .load_value (load_value),
      .load_mode  (load_mode),
      .count      (count),
      .out        (out)
   );

   typedef struct {
      string tag;
      int    exp_count;
      bit    exp_out;
   } item_t;

   item_t sb[$];
   item_t cur;
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;

   // reference model, written from the requirements
   int m_n, m_mode, m_pos, m_cnt;
   bit m_started, m_gq;

   function automatic bit single_m(int m);
      return (m == 0 || m == 1 || m == 4 || m == 5);
   endfunction
   function automatic bit restart_m(int m);
      return (m == 1 || m == 2 || m == 3 || m == 5);
   endfunction
   function automatic bit trig_m(int m);
      return (m == 1 || m == 5);
   endfunction

   function automatic bit exp_level();
      case (m_mode)
         0, 1:    return m_pos >= m_n;
         2:       return !m_gq ? 1'b1 : !(m_started && m_pos == 0);
         3:       return !m_gq ? 1'b1 : (m_pos < (m_n + 1) / 2);
         default: return m_pos != m_n;
      endcase
   endfunction

   function automatic int exp_cnt();
      if (single_m(m_mode)) return m_cnt;
      if (m_mode == 2) return (m_n - m_pos) % 65536;
      return (m_n - ((2 * m_pos) % m_n)) % 65536;
   endfunction

   task automatic step(input bit ld, input int val, input int md,
                       input bit tk, input bit g, input string tag);
      bit rise;
      int nm;
      item_t it;
      load = ld; load_value = val[15:0]; load_mode = md[2:0];
      tick = tk; gate = g;
      rise = g && !m_gq;
      if (ld) begin
         nm = (md == 6) ? 2 : (md == 7) ? 3 : md;
         m_mode = nm;
         m_n = (val == 0) ? 65536 : val;
         m_cnt = m_n % 65536;
         m_started = 0;
         m_pos = trig_m(nm) ? m_n + 1 : 0;
      end else if (rise && restart_m(m_mode)) begin
         m_pos = 0; m_cnt = m_n % 65536; m_started = 0;
      end else if (tk && (g || trig_m(m_mode))) begin
         if (single_m(m_mode)) begin
            m_cnt = (m_cnt + 65535) % 65536;
            if (m_pos != m_n + 1) m_pos++;
         end else begin
            m_started = 1;
            m_pos = (m_pos + 1 == m_n) ? 0 : m_pos + 1;
         end
      end
      m_gq = g;
      @(posedge clk);
      #1;
      it.tag = tag; it.exp_count = exp_cnt(); it.exp_out = exp_level();
      sb.push_back(it);
      @(negedge clk);
   endtask

   task automatic run(input int n, input bit tk, input bit g, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 0, 0, tk, g, tag);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // monitor: pops expected items and compares with the ports
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         cur = sb.pop_front();
         n_cmp++;
         if (count !== cur.exp_count[15:0] || out !== cur.exp_out) begin
            n_bad++;
            $display("FAIL %s: count got %h exp %h, out got %b exp %b",
                     cur.tag, count, cur.exp_count[15:0], out, cur.exp_out);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         summary();
         $finish;
      end
   end

   initial begin
      m_mode = 3; m_n = 65536; m_pos = 0; m_cnt = 0; m_started = 0; m_gq = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: reset state, then default square-wave stepping
      run(2, 1'b0, 1'b1, "R2");
      run(3, 1'b1, 1'b1, "R2");

      // R3 / R10: terminal count, with idle cycles between ticks, then wrap
      step(1'b1, 5, 0, 1'b0, 1'b1, "R3");
      for (int i = 0; i < 6; i++) begin
         step(1'b0, 0, 0, 1'b1, 1'b1, "R3");
         step(1'b0, 0, 0, 1'b0, 1'b1, "R3");
      end
      run(4, 1'b1, 1'b1, "R10");

      // R9: gate low suspends mode 0
      step(1'b1, 6, 0, 1'b0, 1'b1, "R9");
      run(3, 1'b1, 1'b0, "R9");
      run(7, 1'b1, 1'b1, "R9");

      // R4 / R8: one-shot triggered by gate, retriggered mid-count
      step(1'b1, 4, 1, 1'b0, 1'b1, "R4");
      run(3, 1'b1, 1'b1, "R4");
      step(1'b0, 0, 0, 1'b0, 1'b0, "R4");
      step(1'b0, 0, 0, 1'b0, 1'b1, "R4");
      run(2, 1'b1, 1'b0, "R4");
      step(1'b0, 0, 0, 1'b0, 1'b1, "R8");
      run(6, 1'b1, 1'b1, "R8");

      // R5: rate generator
      step(1'b1, 4, 2, 1'b0, 1'b1, "R5");
      run(10, 1'b1, 1'b1, "R5");
      run(2, 1'b1, 1'b0, "R9");
      step(1'b0, 0, 0, 1'b0, 1'b1, "R8");
      run(6, 1'b1, 1'b1, "R8");

      // R6: square wave, odd and even counts, gate low
      step(1'b1, 5, 3, 1'b0, 1'b1, "R6");
      run(12, 1'b1, 1'b1, "R6");
      step(1'b1, 6, 3, 1'b0, 1'b1, "R6");
      run(8, 1'b1, 1'b1, "R6");
      run(3, 1'b1, 1'b0, "R9");
      step(1'b0, 0, 0, 1'b1, 1'b1, "R8");
      run(4, 1'b1, 1'b1, "R6");

      // R7: software strobe, then gate-started strobe
      step(1'b1, 3, 4, 1'b0, 1'b1, "R7");
      run(6, 1'b1, 1'b1, "R7");
      step(1'b1, 3, 5, 1'b0, 1'b1, "R7");
      run(4, 1'b1, 1'b1, "R7");
      step(1'b0, 0, 0, 1'b0, 1'b0, "R7");
      step(1'b0, 0, 0, 1'b0, 1'b1, "R7");
      run(6, 1'b1, 1'b1, "R7");

      // R11: codes 6 and 7 alias rate and square
      step(1'b1, 3, 6, 1'b0, 1'b1, "R11");
      run(7, 1'b1, 1'b1, "R11");
      step(1'b1, 4, 7, 1'b0, 1'b1, "R11");
      run(6, 1'b1, 1'b1, "R11");

      // R12: load with tick, gate edge with tick, load with gate edge
      step(1'b1, 7, 0, 1'b1, 1'b1, "R12");
      run(3, 1'b0, 1'b1, "R12");
      run(2, 1'b1, 1'b1, "R12");
      step(1'b1, 5, 2, 1'b0, 1'b1, "R12");
      run(2, 1'b1, 1'b1, "R12");
      step(1'b0, 0, 0, 1'b0, 1'b0, "R12");
      step(1'b0, 0, 0, 1'b1, 1'b1, "R12");
      run(3, 1'b1, 1'b1, "R12");
      step(1'b0, 0, 0, 1'b0, 1'b0, "R12");
      step(1'b1, 9, 0, 1'b1, 1'b1, "R12");
      run(2, 1'b1, 1'b1, "R12");

      // R1: zero means 65536
      step(1'b1, 0, 2, 1'b0, 1'b1, "R1");
      run(3, 1'b1, 1'b1, "R1");
      step(1'b1, 0, 0, 1'b0, 1'b1, "R1");
      run(65537, 1'b1, 1'b1, "R1");

      @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

endmodule